// File: doc/BRIEF.md
# Target Frequency Duty Ratio Solver

This block works out how to run a processor clock at a reduced average rate by gating it on and off in a repeating pattern. It takes three inputs: a requested frequency, the full stock frequency and an upper bound on the pattern length. From these it finds an 8-bit pair of counts. The "run" count is the number of slots in which the clock runs, and the "halt" count is the number of slots in which the clock is stopped. The pair chosen is the one whose average frequency lands nearest to the request. The block returns the pair together with the frequency it actually achieves, and it sets a modulation-enable flag.

The search is exhaustive. It steps the pattern length from the bound down to one. For every length it makes two truncating divisions on one shared restoring divider that produces one quotient bit per cycle. A candidate replaces the best one found so far when its error is no larger, so among equal candidates the shortest pattern wins. A second operation, chosen by `readback`, works out the effective frequency from the counts and enable flag that the block holds.

A request goes in with a one-cycle `start` pulse. `busy` stays high while the engine works, and `done` pulses once when the registered results are valid.

Top module: `duty_solver`

## Requirements
- R1: A pattern-length bound above 255 is treated as exactly 255.
- R2: The search starts from run count 1, halt count 0 and best frequency equal to the stock frequency. With a bound of 0 the result is therefore the stock frequency.
- R3: For each length i, from the bound down to 1, the run count is the low 8 bits of floor(target·i / stock), and the halt count is (i − run) modulo 256.
- R4: Each candidate's frequency is floor(stock·run / i).
- R5: A candidate is taken when |candidate − target| ≤ |best − target|. Equal errors therefore resolve toward the shorter length. For example, stock 1000, target 500 and bound 10 give run 1 and halt 1.
- R6: A readback operation (`readback`=1 with `start`) returns the stock frequency on `eff_freq` when `mod_en` is 0. Otherwise it returns floor(stock·off_cnt / (off_cnt + on_cnt)).
- R7: When the solved frequency equals the stock frequency, `mod_en` is 0 and both counts are 0. Otherwise `mod_en` is 1 and the chosen counts are output.
- R8: `start` is ignored while `busy` is high. A new request or new inputs during a run do not change its result.
- R9: `done` is high for exactly one cycle per finished operation, and `busy` is high from the cycle after an accepted solve until `done`.
- R10: A stock frequency of 0 makes either operation end one cycle after `start`, with `err`=1 and with the counts, `mod_en` and `best_freq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| readback | input | 1 | 1: effective-frequency readback, 0: solve |
| target_freq | input | FREQ_W | Requested frequency |
| stock_freq | input | FREQ_W | Full (unmodulated) frequency |
| max_len | input | LEN_IN_W | Upper bound on pattern length |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation was rejected (stock of zero) |
| off_cnt | output | CNT_W | Run count (clock running slots) |
| on_cnt | output | CNT_W | Halt count (clock stopped slots) |
| mod_en | output | 1 | Modulation enable |
| best_freq | output | FREQ_W | Frequency achieved by the solved counts |
| eff_freq | output | FREQ_W | Result of the last readback |

## Verification
The assertions assume that a solve request never asks for more than the stock frequency. Under that assumption the run count never exceeds the length, and the two counts add up to at most the clamped bound. The sum check therefore applies only when the latched target does not exceed the latched stock. The divider check assumes a divisor that is not zero, which the engine guarantees by rejecting a stock of zero and by never dividing by a zero length. The stimulus keeps every target at or below its stock. It raises the second `start` of the busy test only while the run is in progress, and it applies the zero-stock case only to the error test.

// File: rtl/duty_pkg.sv
package duty_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OFF_GO,
    ST_OFF_WAIT,
    ST_FRQ_GO,
    ST_FRQ_WAIT,
    ST_JUDGE,
    ST_FINISH,
    ST_RB_GO,
    ST_RB_WAIT
  } solve_st_e;

  // distance between two unsigned values
  function automatic logic [63:0] abs_diff(input logic [63:0] a, input logic [63:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  // limit a requested length to the allowed ceiling
  function automatic logic [15:0] clamp_len(input logic [15:0] req, input logic [15:0] lim);
    return (req > lim) ? lim : req;
  endfunction

endpackage

// File: rtl/duty_divider.sv
module duty_divider #(
  parameter int DVD_W = 40,
  parameter int DVS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic [DVD_W-1:0] quo,
  output logic             fin
);
  localparam int CW = $clog2(DVD_W + 1);
  localparam int PW = DVD_W + DVS_W;

  logic [DVD_W-1:0] q;
  logic [DVD_W-1:0] dvd_l;
  logic [DVS_W:0]   r;
  logic [DVS_W-1:0] dvs;
  logic [CW-1:0]    cnt;
  logic             run;

  logic [DVS_W:0] shifted;
  logic [DVS_W:0] trial;
  logic           step_ok;

  always_comb begin
    shifted = {r[DVS_W-1:0], q[DVD_W-1]};
    trial   = shifted - {1'b0, dvs};
    step_ok = ~trial[DVS_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      dvd_l <= '0;
      r     <= '0;
      dvs   <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      fin   <= 1'b0;
    end else if (go) begin
      q     <= dividend;
      dvd_l <= dividend;
      r     <= '0;
      dvs   <= divisor;
      cnt   <= CW'(DVD_W);
      run   <= 1'b1;
      fin   <= 1'b0;
    end else if (run) begin
      q   <= {q[DVD_W-2:0], step_ok};
      r   <= step_ok ? trial : shifted;
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) begin
        run <= 1'b0;
        fin <= 1'b1;
      end
    end else begin
      fin <= 1'b0;
    end
  end

  assign quo = q;

  // quotient and remainder reconstruct the dividend, remainder below divisor (truncation)
  assert_div_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && dvs != '0) |->
      ((PW'(q) * PW'(dvs) + PW'(r[DVS_W-1:0]) == PW'(dvd_l)) && (r[DVS_W-1:0] < dvs)));

endmodule

// File: rtl/duty_judge.sv
module duty_judge #(
  parameter int W = 40
) (
  input  logic [W-1:0] cand,
  input  logic [W-1:0] best,
  input  logic [W-1:0] target,
  output logic         take
);
  import duty_pkg::*;

  logic [63:0] cand_err;
  logic [63:0] best_err;

  always_comb begin
    cand_err = abs_diff(64'(cand), 64'(target));
    best_err = abs_diff(64'(best), 64'(target));
    take     = (cand_err <= best_err);
  end

endmodule

// File: rtl/duty_solver.sv
module duty_solver #(
  parameter int FREQ_W    = 32,
  parameter int CNT_W     = 8,
  parameter int LEN_IN_W  = 9,
  parameter int LEN_LIMIT = 255
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                readback,
  input  logic [FREQ_W-1:0]   target_freq,
  input  logic [FREQ_W-1:0]   stock_freq,
  input  logic [LEN_IN_W-1:0] max_len,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [CNT_W-1:0]    off_cnt,
  output logic [CNT_W-1:0]    on_cnt,
  output logic                mod_en,
  output logic [FREQ_W-1:0]   best_freq,
  output logic [FREQ_W-1:0]   eff_freq
);
  import duty_pkg::*;

  localparam int PROD_W = FREQ_W + CNT_W;

  solve_st_e st;

  logic [FREQ_W-1:0] tgt_l;
  logic [FREQ_W-1:0] stk_l;
  logic [CNT_W-1:0]  i_cur;
  logic [CNT_W-1:0]  len_l;
  logic [CNT_W-1:0]  c_off;
  logic [CNT_W-1:0]  c_on;
  logic [PROD_W-1:0] c_freq;
  logic [CNT_W-1:0]  w_off;
  logic [CNT_W-1:0]  w_on;
  logic [PROD_W-1:0] w_best;

  // named internal events
  logic              div_go;
  logic              div_fin;
  logic [PROD_W-1:0] div_dvd;
  logic [FREQ_W-1:0] div_dvs;
  logic [PROD_W-1:0] div_quo;
  logic              cand_take;
  logic              scan_last;
  logic [CNT_W-1:0]  len_cl;
  logic              stock_zero;

  assign len_cl     = CNT_W'(clamp_len(16'(max_len), 16'(LEN_LIMIT)));
  assign stock_zero = (stock_freq == '0);
  assign scan_last  = (i_cur == CNT_W'(1));
  assign busy       = (st != ST_IDLE);

  always_comb begin
    div_go  = 1'b0;
    div_dvd = '0;
    div_dvs = '0;
    unique case (st)
      ST_OFF_GO: begin
        div_go  = 1'b1;
        div_dvd = PROD_W'(tgt_l) * PROD_W'(i_cur);
        div_dvs = stk_l;
      end
      ST_FRQ_GO: begin
        div_go  = 1'b1;
        div_dvd = PROD_W'(stk_l) * PROD_W'(c_off);
        div_dvs = FREQ_W'(i_cur);
      end
      ST_RB_GO: begin
        div_go  = 1'b1;
        div_dvd = PROD_W'(stk_l) * PROD_W'(off_cnt);
        div_dvs = FREQ_W'(off_cnt) + FREQ_W'(on_cnt);
      end
      default: ;
    endcase
  end

  duty_divider #(.DVD_W(PROD_W), .DVS_W(FREQ_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (div_dvd),
    .divisor  (div_dvs),
    .quo      (div_quo),
    .fin      (div_fin)
  );

  duty_judge #(.W(PROD_W)) u_judge (
    .cand   (c_freq),
    .best   (w_best),
    .target (PROD_W'(tgt_l)),
    .take   (cand_take)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      tgt_l     <= '0;
      stk_l     <= '0;
      i_cur     <= '0;
      len_l     <= '0;
      c_off     <= '0;
      c_on      <= '0;
      c_freq    <= '0;
      w_off     <= '0;
      w_on      <= '0;
      w_best    <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      off_cnt   <= '0;
      on_cnt    <= '0;
      mod_en    <= 1'b0;
      best_freq <= '0;
      eff_freq  <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            if (stock_zero) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else if (readback) begin
              err   <= 1'b0;
              stk_l <= stock_freq;
              if (!mod_en) begin
                eff_freq <= stock_freq;
                done     <= 1'b1;
              end else begin
                st <= ST_RB_GO;
              end
            end else begin
              err    <= 1'b0;
              tgt_l  <= target_freq;
              stk_l  <= stock_freq;
              w_off  <= CNT_W'(1);
              w_on   <= '0;
              w_best <= PROD_W'(stock_freq);
              i_cur  <= len_cl;
              len_l  <= len_cl;
              st     <= (len_cl == '0) ? ST_FINISH : ST_OFF_GO;
            end
          end
        end
        ST_OFF_GO: st <= ST_OFF_WAIT;
        ST_OFF_WAIT: begin
          if (div_fin) begin
            c_off <= div_quo[CNT_W-1:0];
            c_on  <= i_cur - div_quo[CNT_W-1:0];
            st    <= ST_FRQ_GO;
          end
        end
        ST_FRQ_GO: st <= ST_FRQ_WAIT;
        ST_FRQ_WAIT: begin
          if (div_fin) begin
            c_freq <= div_quo;
            st     <= ST_JUDGE;
          end
        end
        ST_JUDGE: begin
          if (cand_take) begin
            w_off  <= c_off;
            w_on   <= c_on;
            w_best <= c_freq;
          end
          if (scan_last) begin
            st <= ST_FINISH;
          end else begin
            i_cur <= i_cur - CNT_W'(1);
            st    <= ST_OFF_GO;
          end
        end
        ST_FINISH: begin
          if (w_best == PROD_W'(stk_l)) begin
            off_cnt <= '0;
            on_cnt  <= '0;
            mod_en  <= 1'b0;
          end else begin
            off_cnt <= w_off;
            on_cnt  <= w_on;
            mod_en  <= 1'b1;
          end
          best_freq <= w_best[FREQ_W-1:0];
          done      <= 1'b1;
          st        <= ST_IDLE;
        end
        ST_RB_GO: st <= ST_RB_WAIT;
        ST_RB_WAIT: begin
          if (div_fin) begin
            eff_freq <= div_quo[FREQ_W-1:0];
            done     <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // done only ever appears once the engine is back to idle
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // a done pulse is not stretched unless a fresh request was made
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  // latched request does not move while a run is in flight
  assert_hold_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(tgt_l) && $stable(stk_l)));

  // counts of a valid solve never span more than the clamped bound
  assert_sum_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && mod_en && (tgt_l <= stk_l)) |->
      ((CNT_W+1)'(off_cnt) + (CNT_W+1)'(on_cnt) <= (CNT_W+1)'(len_l)));

  // disabled modulation always reports zero counts
  assert_disable_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && !mod_en) |-> (off_cnt == '0 && on_cnt == '0));

  // a rejected request leaves the programmed result alone
  assert_err_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> ($stable(off_cnt) && $stable(on_cnt) && $stable(mod_en) && $stable(best_freq)));

endmodule

// File: tb/duty_solver_test.sv
module duty_solver_test;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        readback;
  logic [31:0] target_freq;
  logic [31:0] stock_freq;
  logic [8:0]  max_len;
  logic        busy;
  logic        done;
  logic        err;
  logic [7:0]  off_cnt;
  logic [7:0]  on_cnt;
  logic        mod_en;
  logic [31:0] best_freq;
  logic [31:0] eff_freq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  duty_solver uut (
    .clk(clk), .rst_n(rst_n), .start(start), .readback(readback),
    .target_freq(target_freq), .stock_freq(stock_freq), .max_len(max_len),
    .busy(busy), .done(done), .err(err), .off_cnt(off_cnt), .on_cnt(on_cnt),
    .mod_en(mod_en), .best_freq(best_freq), .eff_freq(eff_freq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      n_chk = n_chk + 1;
      $display("FAIL watchdog: run did not end (act=%0d cycles exp<150000)", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic longint absl(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  // restatement of the requirements as a plain software search
  function automatic void model(input longint tgt, input longint stk, input int mx,
                                output longint roff, output longint ron,
                                output longint rfr, output longint ren);
    int m;
    longint bo, bn, bf, po, pn, pf;
    m  = (mx > 255) ? 255 : mx;
    bo = 1; bn = 0; bf = stk;
    for (int i = m; i >= 1; i--) begin
      po = (tgt * i / stk) % 256;
      pn = (i - po + 256) % 256;
      pf = stk * po / i;
      if (absl(pf - tgt) <= absl(bf - tgt)) begin
        bo = po; bn = pn; bf = pf;
      end
    end
    rfr = bf;
    if (bf == stk) begin
      ren = 0; roff = 0; ron = 0;
    end else begin
      ren = 1; roff = bo; ron = bn;
    end
  endfunction

  // issue one request and wait for completion; returns cycles waited
  task automatic issue(input bit rb, input longint tgt, input longint stk, input int len,
                       output int waited);
    @(negedge clk);
    readback    = rb;
    target_freq = 32'(tgt);
    stock_freq  = 32'(stk);
    max_len     = 9'(len);
    start       = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    waited = 1;
    while (!done && waited < 60000) begin
      @(negedge clk);
      waited = waited + 1;
    end
  endtask

  task automatic solve_and_compare(input string tag, input longint tgt, input longint stk,
                                   input int len);
    longint eo, en, ef, ee;
    int w;
    model(tgt, stk, len, eo, en, ef, ee);
    issue(1'b0, tgt, stk, len, w);
    chk({tag, " done seen R9"}, done, 1);
    chk({tag, " run count R3"}, off_cnt, eo);
    chk({tag, " halt count R3"}, on_cnt, en);
    chk({tag, " freq R4"}, best_freq, ef);
    chk({tag, " enable R7"}, mod_en, ee);
    @(negedge clk);
    chk({tag, " done single R9"}, done, 0);
  endtask

  task automatic t_reset;
    chk("reset busy R9", busy, 0);
    chk("reset done R9", done, 0);
    chk("reset counts R7", {off_cnt, on_cnt}, 0);
    chk("reset enable R6", mod_en, 0);
  endtask

  task automatic t_tie;
    int w;
    issue(1'b0, 500, 1000, 10, w);
    chk("tie run R5", off_cnt, 1);
    chk("tie halt R5", on_cnt, 1);
    chk("tie freq R5", best_freq, 500);
    chk("tie enable R7", mod_en, 1);
  endtask

  task automatic t_patterns;
    solve_and_compare("pat-a", 7000, 30000, 17);
    solve_and_compare("pat-b", 1234, 33333, 40);
    solve_and_compare("pat-c", 999, 1000, 30);
    solve_and_compare("pat-d", 73000, 200000, 255);
  endtask

  task automatic t_clamp;
    longint eo, en, ef, ee;
    int w;
    model(91000, 200000, 255, eo, en, ef, ee);
    issue(1'b0, 91000, 200000, 300, w);
    chk("clamp run R1", off_cnt, eo);
    chk("clamp halt R1", on_cnt, en);
    chk("clamp freq R1", best_freq, ef);
  endtask

  task automatic t_zero_len;
    int w;
    issue(1'b0, 100, 1000, 0, w);
    chk("zero bound freq R2", best_freq, 1000);
    chk("zero bound enable R2", mod_en, 0);
    chk("zero bound counts R7", {off_cnt, on_cnt}, 0);
  endtask

  task automatic t_full_speed;
    int w;
    issue(1'b0, 5000, 5000, 12, w);
    chk("full speed enable R7", mod_en, 0);
    chk("full speed counts R7", {off_cnt, on_cnt}, 0);
    chk("full speed freq R7", best_freq, 5000);
  endtask

  task automatic t_readback;
    longint eo, en, ef, ee;
    int w;
    model(300, 1000, 10, eo, en, ef, ee);
    issue(1'b0, 300, 1000, 10, w);
    issue(1'b1, 0, 1000, 0, w);
    chk("readback enabled R6", eff_freq, 1000 * eo / (eo + en));
    issue(1'b0, 1000, 1000, 4, w);
    issue(1'b1, 0, 1000, 0, w);
    chk("readback disabled R6", eff_freq, 1000);
  endtask

  task automatic t_busy_ignore;
    longint eo, en, ef, ee;
    int w;
    model(250, 1000, 20, eo, en, ef, ee);
    @(negedge clk);
    readback = 1'b0; target_freq = 250; stock_freq = 1000; max_len = 20; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("busy after start R9", busy, 1);
    repeat (10) @(negedge clk);
    target_freq = 900; max_len = 3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!done && w < 60000) begin
      @(negedge clk);
      w = w + 1;
    end
    chk("busy ignore run R8", off_cnt, eo);
    chk("busy ignore halt R8", on_cnt, en);
    chk("busy ignore freq R8", best_freq, ef);
  endtask

  task automatic t_zero_stock;
    logic [7:0]  so, sn;
    logic [31:0] sf;
    logic        se;
    int w;
    issue(1'b0, 400, 1000, 9, w);
    so = off_cnt; sn = on_cnt; sf = best_freq; se = mod_en;
    issue(1'b0, 400, 0, 9, w);
    chk("zero stock latency R10", w, 1);
    chk("zero stock err R10", err, 1);
    chk("zero stock run kept R10", off_cnt, so);
    chk("zero stock halt kept R10", on_cnt, sn);
    chk("zero stock freq kept R10", best_freq, sf);
    chk("zero stock enable kept R10", mod_en, se);
    issue(1'b1, 0, 0, 0, w);
    chk("zero stock readback err R10", err, 1);
    chk("zero stock readback kept R10", off_cnt, so);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; readback = 1'b0;
    target_freq = '0; stock_freq = '0; max_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tie();
    t_patterns();
    t_clamp();
    t_zero_len();
    t_full_speed();
    t_readback();
    t_busy_ignore();
    t_zero_stock();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule